// File: doc/BRIEF.md
# Flash-to-Memory Block Copy Engine

This engine moves a contiguous block of serial-flash contents into system memory without processor involvement. Software loads three address registers (the flash source address, the first destination address and the exclusive destination end address) and then sets the go bit in the control register. The engine issues one read command to a flash byte source. It collects the returned bytes sixteen at a time into a 128-bit beat and writes each beat to a simple valid/ready memory write port at rising destination addresses.

The go bit reads back as a busy indicator and drops by itself when the last beat has been accepted. In that same clock cycle the done flag (bit 7 of an 8-bit interrupt status register) is set. The interrupt output is the OR of the status bits that are also set in the interrupt enable register. Status bits clear when 1 is written to them. A start request with misaligned addresses, or with an end address that is not above the destination start, is refused and raises an error flag.

The sequencer is a four-state machine. IDLE moves to ISSUE when a start is accepted. ISSUE moves to FILL when the flash command is taken. FILL moves to WRITE when the sixteenth byte of a beat arrives. WRITE returns to FILL when a beat that is not the last is accepted, and goes to IDLE when the last beat is accepted.

Top module: `fdma_engine`

## Requirements
- R1: After reset the control register reads 0, the interrupt status register reads 0, and `irq`, `rd_cmd_valid` and `mem_wr_valid` are low.
- R2: Register indices are control=0, source=1, destination=2, end=3, status=4, enable=5. Writing control with bit 0 set while idle and with valid addresses starts a transfer. Control bit 0 then reads 1, and exactly one flash command is presented, carrying the source address and the byte count end minus destination.
- R3: Each beat holds 16 consecutive flash bytes in little-endian order: the byte from the lowest flash address sits in bits 7:0 and the byte from the highest in bits 127:120.
- R4: Beats are written at destination, destination+16 and onward, stopping before the end address, so (end minus destination)/16 beats are written in total.
- R5: Control bit 0 reads 0 and status bit 7 reads 1 from the cycle after the last beat is accepted. Both change on the same clock edge.
- R6: `irq` is high exactly when some status bit and the matching enable bit are both 1. If status bit 7 is set and enable bit 7 is clear, `irq` stays low.
- R7: Writing the status register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R8: A start request is refused if the low four bits of the source, destination or end address are not zero, or if the end address is not greater than the destination. A refused request issues no flash command, leaves control bit 0 at 0 and sets the error flag (control bit 1). The next accepted start clears the error flag.
- R9: A start request made while busy is ignored, and writes to the address registers made while busy do not affect the transfer in progress. Exactly one command is issued, and the data comes from the original source.
- R10: While a beat is waiting for `mem_wr_ready`, its address and data stay stable and `fl_byte_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rd_cmd_valid | output | 1 | Flash read command valid |
| rd_cmd_ready | input | 1 | Flash read command accepted |
| rd_cmd_addr | output | 32 | Flash start address of the command |
| rd_cmd_bytes | output | 32 | Byte count of the command |
| fl_byte_valid | input | 1 | Flash byte valid |
| fl_byte_ready | output | 1 | Engine accepts a flash byte |
| fl_byte_data | input | 8 | Flash byte |
| mem_wr_valid | output | 1 | Memory write beat valid |
| mem_wr_ready | input | 1 | Memory write beat accepted |
| mem_wr_addr | output | 32 | Byte address of the beat |
| mem_wr_data | output | 128 | Beat data, little-endian |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a memory stall during a beat while the flash source still has bytes to offer. In that case back-pressure has to reach the byte interface and the beat must stay stable. The bench reaches it by pulling `mem_wr_ready` low on a fixed cycle pattern while the byte source gaps on a different pattern, so the stalls fall in many different phases. A second hard case is a start request or a source rewrite that arrives in the middle of a transfer. The bench writes both a few cycles after a start and checks that only one command appears and that every beat carries data from the original source.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FILL,
        ST_WRITE
    } fdma_state_e;

    localparam int          IRQ_W    = 8;
    localparam int          DONE_BIT = 7;
    localparam int          RIDX_W   = 3;

    localparam logic [RIDX_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [RIDX_W-1:0] REG_SRC   = 3'd1;
    localparam logic [RIDX_W-1:0] REG_DST   = 3'd2;
    localparam logic [RIDX_W-1:0] REG_DEND  = 3'd3;
    localparam logic [RIDX_W-1:0] REG_ISTAT = 3'd4;
    localparam logic [RIDX_W-1:0] REG_IEN   = 3'd5;
endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
    import fdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BEAT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              busy,
    input  logic              done,
    output logic              start,
    output logic [AW-1:0]     src_q,
    output logic [AW-1:0]     dst_q,
    output logic [AW-1:0]     dend_q,
    output logic [IRQ_W-1:0]  istat_q,
    output logic              irq
);
    localparam int OFS = $clog2(BEAT_BYTES);

    logic [IRQ_W-1:0] ien_q;
    logic [IRQ_W-1:0] istat_d;
    logic             err_q;
    logic             go_req;
    logic             misaligned;
    logic             bad_len;

    assign go_req     = reg_we && (reg_addr == REG_CTRL) && reg_wdata[0] && !busy;
    assign misaligned = (|src_q[OFS-1:0]) || (|dst_q[OFS-1:0]) || (|dend_q[OFS-1:0]);
    assign bad_len    = (dend_q <= dst_q);
    assign start      = go_req && !misaligned && !bad_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            dend_q <= '0;
            ien_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_SRC:  src_q  <= reg_wdata;
                REG_DST:  dst_q  <= reg_wdata;
                REG_DEND: dend_q <= reg_wdata;
                REG_IEN:  ien_q  <= reg_wdata[IRQ_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (start)  err_q <= 1'b0;
        else if (go_req) err_q <= 1'b1;
    end

    always_comb begin
        istat_d = istat_q;
        if (reg_we && (reg_addr == REG_ISTAT))
            istat_d = istat_q & ~reg_wdata[IRQ_W-1:0];
        if (done)
            istat_d[DONE_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) istat_q <= '0;
        else        istat_q <= istat_d;
    end

    assign irq = |(istat_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[0] = busy;
                reg_rdata[1] = err_q;
            end
            REG_SRC:   reg_rdata = src_q;
            REG_DST:   reg_rdata = dst_q;
            REG_DEND:  reg_rdata = dend_q;
            REG_ISTAT: reg_rdata[IRQ_W-1:0] = istat_q;
            REG_IEN:   reg_rdata[IRQ_W-1:0] = ien_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fdma_packer.sv
module fdma_packer #(
    parameter int BEAT_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    take,
    input  logic [7:0]              byte_in,
    output logic                    last,
    output logic [8*BEAT_BYTES-1:0] beat
);
    localparam int CW = $clog2(BEAT_BYTES);

    logic [CW-1:0] cnt_q;

    assign last = take && (cnt_q == CW'(BEAT_BYTES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (last)  cnt_q <= '0;
        else if (take)  cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (take && (cnt_q == CW'(g)))
                lane_q <= byte_in;
        end
        assign beat[8*g +: 8] = lane_q;
    end
endmodule

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
    import fdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BEAT_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [AW-1:0] dend,
    output logic          rd_cmd_valid,
    input  logic          rd_cmd_ready,
    output logic [AW-1:0] rd_cmd_addr,
    output logic [AW-1:0] rd_cmd_bytes,
    input  logic          fl_byte_valid,
    output logic          fl_byte_ready,
    output logic          pk_take,
    output logic          pk_clr,
    input  logic          pk_last,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] end_addr
);
    localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

    fdma_state_e   state_q, state_d;
    logic [AW-1:0] src_q, cur_q, end_q, len_q;
    logic          last_beat;

    assign last_beat = (cur_q + STEP) == end_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)        state_d = ST_ISSUE;
            ST_ISSUE: if (rd_cmd_ready) state_d = ST_FILL;
            ST_FILL:  if (pk_last)      state_d = ST_WRITE;
            ST_WRITE: if (mem_wr_ready) state_d = last_beat ? ST_IDLE : ST_FILL;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_cmd_valid  = 1'b0;
        fl_byte_ready = 1'b0;
        mem_wr_valid  = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: rd_cmd_valid = 1'b1;
            ST_FILL:  fl_byte_ready = 1'b1;
            ST_WRITE: begin
                mem_wr_valid = 1'b1;
                done         = mem_wr_ready && last_beat;
            end
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            cur_q <= '0;
            end_q <= '0;
            len_q <= '0;
        end else if (start && (state_q == ST_IDLE)) begin
            src_q <= src;
            cur_q <= dst;
            end_q <= dend;
            len_q <= dend - dst;
        end else if (mem_wr_valid && mem_wr_ready) begin
            cur_q <= cur_q + STEP;
        end
    end

    assign pk_take      = fl_byte_ready && fl_byte_valid;
    assign pk_clr       = start && (state_q == ST_IDLE);
    assign busy         = (state_q != ST_IDLE);
    assign rd_cmd_addr  = src_q;
    assign rd_cmd_bytes = len_q;
    assign mem_wr_addr  = cur_q;
    assign end_addr     = end_q;
endmodule

// File: rtl/fdma_engine.sv
module fdma_engine
    import fdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BEAT_BYTES = 16,
    localparam int BW        = 8 * BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    output logic              rd_cmd_valid,
    input  logic              rd_cmd_ready,
    output logic [AW-1:0]     rd_cmd_addr,
    output logic [AW-1:0]     rd_cmd_bytes,
    input  logic              fl_byte_valid,
    output logic              fl_byte_ready,
    input  logic [7:0]        fl_byte_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [BW-1:0]     mem_wr_data,
    output logic              irq
);
    logic             start, busy, done;
    logic [AW-1:0]    src_q, dst_q, dend_q, end_addr;
    logic [IRQ_W-1:0] istat;
    logic             pk_take, pk_clr, pk_last;

    fdma_regs #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (done),
        .start     (start),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .dend_q    (dend_q),
        .istat_q   (istat),
        .irq       (irq)
    );

    fdma_ctrl #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .src           (src_q),
        .dst           (dst_q),
        .dend          (dend_q),
        .rd_cmd_valid  (rd_cmd_valid),
        .rd_cmd_ready  (rd_cmd_ready),
        .rd_cmd_addr   (rd_cmd_addr),
        .rd_cmd_bytes  (rd_cmd_bytes),
        .fl_byte_valid (fl_byte_valid),
        .fl_byte_ready (fl_byte_ready),
        .pk_take       (pk_take),
        .pk_clr        (pk_clr),
        .pk_last       (pk_last),
        .mem_wr_valid  (mem_wr_valid),
        .mem_wr_ready  (mem_wr_ready),
        .mem_wr_addr   (mem_wr_addr),
        .busy          (busy),
        .done          (done),
        .end_addr      (end_addr)
    );

    fdma_packer #(.BEAT_BYTES(BEAT_BYTES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pk_clr),
        .take    (pk_take),
        .byte_in (fl_byte_data),
        .last    (pk_last),
        .beat    (mem_wr_data)
    );
endmodule

// File: rtl/fdma_engine_chk.sv
module fdma_engine_chk
    import fdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BEAT_BYTES = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic [IRQ_W-1:0]        istat,
    input logic                    irq,
    input logic                    rd_cmd_valid,
    input logic                    fl_byte_ready,
    input logic                    mem_wr_valid,
    input logic                    mem_wr_ready,
    input logic [AW-1:0]           mem_wr_addr,
    input logic [8*BEAT_BYTES-1:0] mem_wr_data,
    input logic [AW-1:0]           end_addr
);
    localparam int OFS = $clog2(BEAT_BYTES);

    assert_cmd_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid |-> busy);

    assert_beat_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (mem_wr_addr < end_addr) && (mem_wr_addr[OFS-1:0] == '0));

    assert_done_with_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> istat[DONE_BIT]);

    assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (istat != '0));

    assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    assert_no_byte_during_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !fl_byte_ready);
endmodule

bind fdma_engine fdma_engine_chk #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .istat         (istat),
    .irq           (irq),
    .rd_cmd_valid  (rd_cmd_valid),
    .fl_byte_ready (fl_byte_ready),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_ready  (mem_wr_ready),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .end_addr      (end_addr)
);

// File: tb/fdma_engine_bench.sv
module fdma_engine_bench;
    import fdma_pkg::*;

    localparam int AW = 32;
    localparam int BW = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [RIDX_W-1:0] reg_addr = REG_CTRL;
    logic [AW-1:0]     reg_wdata = '0;
    logic [AW-1:0]     reg_rdata;
    logic              rd_cmd_valid;
    logic              rd_cmd_ready = 1'b1;
    logic [AW-1:0]     rd_cmd_addr, rd_cmd_bytes;
    logic              fl_byte_valid = 1'b0;
    logic              fl_byte_ready;
    logic [7:0]        fl_byte_data = '0;
    logic              mem_wr_valid;
    logic              mem_wr_ready = 1'b0;
    logic [AW-1:0]     mem_wr_addr;
    logic [BW-1:0]     mem_wr_data;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    fdma_engine u_fdma_engine (
        .clk (clk), .rst_n (rst_n),
        .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .rd_cmd_valid (rd_cmd_valid), .rd_cmd_ready (rd_cmd_ready),
        .rd_cmd_addr (rd_cmd_addr), .rd_cmd_bytes (rd_cmd_bytes),
        .fl_byte_valid (fl_byte_valid), .fl_byte_ready (fl_byte_ready), .fl_byte_data (fl_byte_data),
        .mem_wr_valid (mem_wr_valid), .mem_wr_ready (mem_wr_ready),
        .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data),
        .irq (irq)
    );

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements) act=%0d cycles exp=fewer", cyc);
            summary_and_end();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8];
    endfunction

    function automatic logic [BW-1:0] beat_exp(input logic [AW-1:0] a);
        logic [BW-1:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = pat(a + AW'(i));
        return r;
    endfunction

    task automatic reg_write(input logic [RIDX_W-1:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = REG_CTRL;
    endtask

    task automatic reg_read(input logic [RIDX_W-1:0] a, output logic [AW-1:0] v);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Runs one transfer; bst/mst give byte-gap and memory-stall periods.
    task automatic run_transfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                                input logic [AW-1:0] dend, input int bst, input int mst,
                                input bit poke, input bit ien_on, input string tag);
        int            exp_beats, beats, ncmd, left;
        logic [AW-1:0] ptr, hold_addr;
        logic [BW-1:0] hold_data;
        bit            hold, fin;
        exp_beats = int'((dend - dst) / 16);
        beats = 0; ncmd = 0; left = 0; ptr = '0; hold = 0; fin = 0;
        hold_addr = '0; hold_data = '0;
        reg_write(REG_IEN, ien_on ? 32'h80 : 32'h0);
        reg_write(REG_ISTAT, 32'hFF);
        reg_write(REG_SRC, src);
        reg_write(REG_DST, dst);
        reg_write(REG_DEND, dend);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = REG_CTRL; reg_wdata = 32'h1;
        for (int it = 0; it < 4000 && !fin; it++) begin
            @(negedge clk);
            reg_we = 1'b0; reg_addr = REG_CTRL;
            if (poke && it == 3) begin reg_we = 1'b1; reg_addr = REG_SRC; reg_wdata = 32'h0000_7700; end
            if (poke && it == 4) begin reg_we = 1'b1; reg_addr = REG_CTRL; reg_wdata = 32'h1; end
            fl_byte_valid = (left > 0) && (bst == 0 || (it % bst) != 0);
            fl_byte_data  = pat(ptr);
            mem_wr_ready  = (mst == 0 || (it % mst) != 1);
            #1;
            if (hold) begin
                check(mem_wr_valid && mem_wr_addr == hold_addr && mem_wr_data == hold_data,
                      {tag, " R10 stalled beat changed"}, BW'(mem_wr_addr), BW'(hold_addr));
                hold = 0;
            end
            if (rd_cmd_valid && rd_cmd_ready) begin
                ncmd++;
                check(rd_cmd_addr == src, {tag, " R2 command address"}, BW'(rd_cmd_addr), BW'(src));
                check(rd_cmd_bytes == dend - dst, {tag, " R2 command byte count"}, BW'(rd_cmd_bytes), BW'(dend - dst));
                ptr = src; left = int'(dend - dst);
            end
            if (fl_byte_valid && fl_byte_ready) begin
                ptr = ptr + 1; left--;
            end
            if (mem_wr_valid && mem_wr_ready) begin
                check(mem_wr_addr == dst + AW'(16 * beats), {tag, " R4 beat address"},
                      BW'(mem_wr_addr), BW'(dst + AW'(16 * beats)));
                check(mem_wr_data == beat_exp(src + AW'(16 * beats)), {tag, " R3 beat data"},
                      mem_wr_data, beat_exp(src + AW'(16 * beats)));
                check(!fl_byte_ready, {tag, " R10 byte ready during beat"}, BW'(fl_byte_ready), '0);
                beats++;
                if (beats == exp_beats) begin
                    check(reg_rdata[0] == 1'b1, {tag, " R2 busy before last beat"}, BW'(reg_rdata), 1);
                    fin = 1;
                end
            end else if (mem_wr_valid) begin
                hold = 1; hold_addr = mem_wr_addr; hold_data = mem_wr_data;
            end
        end
        @(negedge clk);
        fl_byte_valid = 1'b0; mem_wr_ready = 1'b0;
        #1;
        check(beats == exp_beats, {tag, " R4 beat count"}, BW'(beats), BW'(exp_beats));
        check(reg_rdata[1:0] == 2'b00, {tag, " R5 busy cleared after last beat"}, BW'(reg_rdata), 0);
        check(irq == ien_on, {tag, " R6 irq after done"}, BW'(irq), BW'(ien_on));
        check(ncmd == 1, {tag, " R9 one command per transfer"}, BW'(ncmd), 1);
        check(!mem_wr_valid, {tag, " R4 no extra beat"}, BW'(mem_wr_valid), 0);
    endtask

    task automatic t_reset();
        logic [AW-1:0] v;
        reg_read(REG_CTRL, v);
        check(v == 0, "R1 control after reset", BW'(v), 0);
        reg_read(REG_ISTAT, v);
        check(v == 0, "R1 status after reset", BW'(v), 0);
        check(!irq && !rd_cmd_valid && !mem_wr_valid, "R1 outputs idle after reset",
              BW'({irq, rd_cmd_valid, mem_wr_valid}), 0);
    endtask

    task automatic t_basic_and_clear();
        logic [AW-1:0] v;
        run_transfer(32'h0000_1000, 32'h8000_0040, 32'h8000_0080, 0, 0, 0, 1, "basic");
        reg_read(REG_ISTAT, v);
        check(v == 32'h80, "R5 done flag set", BW'(v), 32'h80);
        reg_write(REG_ISTAT, 32'h7F);
        reg_read(REG_ISTAT, v);
        check(v == 32'h80 && irq, "R7 zero bits leave status", BW'(v), 32'h80);
        reg_write(REG_ISTAT, 32'h80);
        reg_read(REG_ISTAT, v);
        check(v == 32'h0 && !irq, "R7 one bit clears status", BW'({irq, v}), 0);
    endtask

    task automatic t_stalls();
        run_transfer(32'h0002_3450, 32'h0000_0100, 32'h0000_0130, 3, 4, 0, 1, "stall_a");
        run_transfer(32'h0000_00F0, 32'h0000_0200, 32'h0000_0250, 5, 2, 0, 1, "stall_b");
    endtask

    task automatic t_masked();
        logic [AW-1:0] v;
        run_transfer(32'h0000_0010, 32'h0000_0300, 32'h0000_0310, 0, 3, 0, 0, "masked");
        reg_read(REG_ISTAT, v);
        check(v == 32'h80 && !irq, "R6 masked status keeps irq low", BW'({irq, v}), 32'h80);
        reg_write(REG_IEN, 32'h80);
        #1 check(irq, "R6 enabling raises irq", BW'(irq), 1);
        reg_write(REG_ISTAT, 32'hFF);
    endtask

    task automatic refused(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [AW-1:0] e, input string tag);
        logic [AW-1:0] v;
        bit            seen;
        reg_write(REG_SRC, s);
        reg_write(REG_DST, d);
        reg_write(REG_DEND, e);
        reg_write(REG_CTRL, 32'h1);
        #1 seen = rd_cmd_valid;
        reg_read(REG_CTRL, v);
        check(v == 32'h2, {tag, " R8 refused start sets error"}, BW'(v), 2);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1 if (rd_cmd_valid) seen = 1;
        end
        check(!seen, {tag, " R8 no command after refusal"}, BW'(seen), 0);
    endtask

    task automatic t_errors();
        logic [AW-1:0] v;
        refused(32'h0000_0004, 32'h0000_0100, 32'h0000_0140, "src_misal");
        refused(32'h0000_0000, 32'h0000_0100, 32'h0000_0148, "end_misal");
        refused(32'h0000_0000, 32'h0000_0100, 32'h0000_0100, "zero_len");
        refused(32'h0000_0000, 32'h0000_0200, 32'h0000_0100, "neg_len");
        run_transfer(32'h0000_0400, 32'h0000_0500, 32'h0000_0520, 0, 0, 0, 0, "after_err");
        reg_read(REG_CTRL, v);
        check(v == 0, "R8 accepted start clears error", BW'(v), 0);
    endtask

    task automatic t_busy_poke();
        run_transfer(32'h0000_0A00, 32'h0000_0600, 32'h0000_0640, 2, 3, 1, 1, "poke");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_and_clear();
        t_stalls();
        t_masked();
        t_errors();
        t_busy_poke();
        repeat (4) @(negedge clk);
        summary_and_end();
    end
endmodule